// File: doc/BRIEF.md
# Memory-Mapped Byte Output Port

This block lets a processor push a stream of bytes, one at a time, to a slow byte consumer. Two word addresses on a simple single-cycle register bus reach the block. One holds the outgoing byte. The other is a control word that carries three bits:

- a pending flag, which software sets and hardware clears;
- an interrupt enable;
- a sticky overrun flag.

Software writes a byte and then sets the pending flag. That flag drives the outgoing stream's `valid`. The consumer takes the byte by raising `ready`, and the flag then drops.

Software can learn that the port is free in either of two ways. It can read the control word in a loop until the pending flag reads clear. Alternatively, it can enable the interrupt, which stays high for as long as the port is free.

The consumer side is a valid/ready stream. `dev_valid` equals the pending flag. `dev_data` holds steady while `dev_valid` is high. The transfer completes on the rising clock edge where `dev_valid` and `dev_ready` are both high. The consumer applies back-pressure simply by keeping `dev_ready` low. `dev_ready` has no effect while `dev_valid` is low.

Top module: `byte_port_hs`

## Requirements
- R1: After reset, the control word reads zero, `dev_valid` is low and `irq` is low.
- R2: A bus write to the data address (word 0) while the pending flag is clear stores the byte. The byte can then be read back at word 0, and it appears on `dev_data`.
- R3: A control write (word 1) with bit 0 set, made while the pending flag is clear, sets the pending flag (control bit 0) from the next cycle. `dev_valid` follows the flag.
- R4: The pending flag clears on the edge where `dev_valid` and `dev_ready` are both high. `dev_ready` has no effect while `dev_valid` is low.
- R5: While `dev_valid` is high and no transfer has taken place, `dev_data` does not change.
- R6: A data write made while the pending flag is set is dropped, and it sets the overrun flag (control bit 2).
- R7: The overrun flag is sticky. A control write with bit 2 set clears it, and a control write with bit 2 clear leaves it unchanged.
- R8: The interrupt enable is control bit 1. Control writes set and clear it, and it reads back as written.
- R9: `irq` is high exactly when the interrupt enable is set and the pending flag is clear.
- R10: A control write with bit 0 clear never clears the pending flag. Only the consumer handshake clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Word address: 0 selects data, 1 selects control |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| dev_valid | output | 1 | A byte is on offer to the consumer |
| dev_data | output | DATA_W | Byte on offer |
| dev_ready | input | 1 | The consumer takes the byte this cycle |
| irq | output | 1 | Port-free interrupt, level high |

## Verification
A pending flag stuck high shows within one cycle: `dev_valid` stays high after a completed handshake and `irq` stays low. A flag that clears early drops `dev_valid` before `dev_ready` is raised. A holding register that a data write can overwrite while a byte is pending changes `dev_data` on the following cycle. A lost overrun or enable bit is wrong on the very next read of the control word.

// File: rtl/byte_port_pkg.sv
package byte_port_pkg;
  localparam int CTRL_PEND = 0;
  localparam int CTRL_IEN  = 1;
  localparam int CTRL_OVR  = 2;
  localparam int CTRL_BITS = 3;

  typedef enum logic [1:0] {
    RSEL_DATA = 2'd0,
    RSEL_CTRL = 2'd1,
    RSEL_NONE = 2'd2
  } rsel_e;
endpackage

// File: rtl/byte_port_decode.sv
module byte_port_decode #(
  parameter int ADDR_W    = 2,
  parameter int DATA_ADDR = 0,
  parameter int CTRL_ADDR = 1
) (
  input  logic                      bus_sel,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  output logic                      wr_data,
  output logic                      wr_ctrl,
  output byte_port_pkg::rsel_e      rsel
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

  always_comb begin
    wr_data = bus_sel && bus_we && (bus_addr == A_DATA);
    wr_ctrl = bus_sel && bus_we && (bus_addr == A_CTRL);
    if (bus_addr == A_DATA)      rsel = byte_port_pkg::RSEL_DATA;
    else if (bus_addr == A_CTRL) rsel = byte_port_pkg::RSEL_CTRL;
    else                         rsel = byte_port_pkg::RSEL_NONE;
  end
endmodule

// File: rtl/byte_port_hold.sv
module byte_port_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic              set_pend,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dev_ready,
  output logic              pend_q,
  output logic [DATA_W-1:0] data_q,
  output logic              overrun_hit
);
  logic take;
  logic load;

  always_comb begin
    take        = pend_q && dev_ready;
    load        = wr_data && !pend_q;
    overrun_hit = wr_data && pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (load) data_q <= wdata;
      if (take)                    pend_q <= 1'b0;
      else if (set_pend && !pend_q) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/byte_port_ctrl.sv
module byte_port_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wr_ien,
  input  logic wr_ovr_clr,
  input  logic overrun_hit,
  input  logic pend_q,
  output logic ien_q,
  output logic ovr_q,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (wr_ctrl) ien_q <= wr_ien;
      if (overrun_hit)               ovr_q <= 1'b1;
      else if (wr_ctrl && wr_ovr_clr) ovr_q <= 1'b0;
    end
  end

  always_comb irq = ien_q && !pend_q;
endmodule

// File: rtl/byte_port_hs.sv
module byte_port_hs #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int DATA_ADDR = 0,
  parameter int CTRL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              dev_valid,
  output logic [DATA_W-1:0] dev_data,
  input  logic              dev_ready,
  output logic              irq
);
  import byte_port_pkg::*;

  logic              wr_data;
  logic              wr_ctrl;
  rsel_e             rsel;
  logic              pend_q;
  logic              ien_q;
  logic              ovr_q;
  logic              overrun_hit;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] ctrl_word;

  byte_port_decode #(
    .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_dec (
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .wr_data(wr_data), .wr_ctrl(wr_ctrl), .rsel(rsel)
  );

  byte_port_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
    .set_pend(wr_ctrl && bus_wdata[CTRL_PEND]),
    .wdata(bus_wdata), .dev_ready(dev_ready),
    .pend_q(pend_q), .data_q(data_q), .overrun_hit(overrun_hit)
  );

  byte_port_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl),
    .wr_ien(bus_wdata[CTRL_IEN]), .wr_ovr_clr(bus_wdata[CTRL_OVR]),
    .overrun_hit(overrun_hit), .pend_q(pend_q),
    .ien_q(ien_q), .ovr_q(ovr_q), .irq(irq)
  );

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[CTRL_PEND] = pend_q;
    ctrl_word[CTRL_IEN]  = ien_q;
    ctrl_word[CTRL_OVR]  = ovr_q;
    case (rsel)
      RSEL_DATA: bus_rdata = data_q;
      RSEL_CTRL: bus_rdata = ctrl_word;
      default:   bus_rdata = '0;
    endcase
    dev_valid = pend_q;
    dev_data  = data_q;
  end
endmodule

// File: rtl/byte_port_hs_chk.sv
module byte_port_hs_chk #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int DATA_ADDR = 0,
  parameter int CTRL_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              dev_valid,
  input logic [DATA_W-1:0] dev_data,
  input logic              dev_ready,
  input logic              irq,
  input logic              ovr_q
);
  a_r4_clear_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid && dev_ready |=> !dev_valid);

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid && !dev_ready |=> dev_valid && $stable(dev_data));

  a_r9_irq_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !dev_valid);

  a_r6_overrun_on_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && bus_addr == ADDR_W'(DATA_ADDR) && dev_valid |=> ovr_q);

  a_r3_set_pending: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && bus_addr == ADDR_W'(CTRL_ADDR) && bus_wdata[0] && !dev_valid
    |=> dev_valid);
endmodule

bind byte_port_hs byte_port_hs_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dev_valid(dev_valid),
  .dev_data(dev_data), .dev_ready(dev_ready), .irq(irq), .ovr_q(ovr_q)
);

// File: tb/byte_port_hs_tb_top.sv
module byte_port_hs_tb_top;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam realtime TCK = 5ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          dev_valid;
  logic [DW-1:0] dev_data;
  logic          dev_ready = 1'b0;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(TCK/2) clk = ~clk;

  byte_port_hs #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_valid(dev_valid), .dev_data(dev_data), .dev_ready(dev_ready), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = AW'(a);
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic take();
    @(negedge clk);
    dev_ready = 1'b1;
    @(negedge clk);
    dev_ready = 1'b0;
  endtask

  initial begin
    #(TCK * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1, r);
    check("R1 ctrl", r, 0);
    check("R1 valid", int'(dev_valid), 0);
    check("R1 irq", int'(irq), 0);

    // ready while idle does nothing (R4)
    take();
    check("R4 idle ready", int'(dev_valid), 0);

    // control bits: pending=0, ien=1, ovr=2
    for (int v = 0; v < 256; v++) begin
      wr(0, v);
      rd(0, r);
      check("R2 readback", r, v);
      check("R2 dev_data", int'(dev_data), v);
      wr(1, 3'b011);
      check("R3 valid", int'(dev_valid), 1);
      rd(1, r);
      check("R3 ctrl", r & 3, 3);
      check("R9 irq busy", int'(irq), 0);
      wr(0, (~v) & 8'hff);
      check("R5 data held", int'(dev_data), v);
      rd(1, r);
      check("R6 overrun", (r >> 2) & 1, 1);
      wr(1, 3'b010);
      check("R10 pend kept", int'(dev_valid), 1);
      rd(1, r);
      check("R7 ovr sticky", (r >> 2) & 1, 1);
      wr(1, 3'b110);
      rd(1, r);
      check("R7 ovr clear", (r >> 2) & 1, 0);
      for (int w = 0; w < (v % 4); w++) begin
        @(negedge clk);
        check("R5 wait", int'(dev_valid), 1);
      end
      take();
      check("R4 cleared", int'(dev_valid), 0);
      check("R9 irq free", int'(irq), 1);
    end

    // enable / pending matrix for R8 and R9
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < 2; p++) begin
        wr(1, e << 1);
        if (p == 1) wr(1, 1 | (e << 1));
        rd(1, r);
        check("R8 ien", (r >> 1) & 1, e);
        check("R9 irq", int'(irq), e & (1 - p));
        if (p == 1) take();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule